// File: doc/BRIEF.md
# Embedded Controller Host Mailbox

This block sits between a host bus and an embedded microcontroller. It gives the operating system three byte-wide views: a status byte, a command port that the host can only write, and a data port that the host can both read and write. Command bytes and data bytes from the host land in one shared inbound latch. A status bit records whether the most recent host write came through the command port or the data port. This lets firmware tell a new command from an argument byte.

Traffic toward the host goes through a separate outbound latch. Two buffer-full flags carry the handshake. The input-full flag rises on any host write and drops when firmware takes the inbound byte. The output-full flag rises when firmware loads a reply and drops when the host reads the data port. The remaining status bits are the burst flag, the SCI and SMI event-pending flags and two general bits. Only firmware writes these bits, through its own flag port. Host accesses never change them.

Top module: `ec_host_mailbox`

## Requirements
- R1: After reset every status bit is 0, the inbound latch reads 0 and a host data-port read returns 0.
- R2: A host write with the command port selected (`host_sel_data`=0) stores the byte in the inbound latch and, from the next cycle, sets input-full (status bit 1) and the command indicator (status bit 3).
- R3: A host write with the data port selected (`host_sel_data`=1) stores the byte in the inbound latch, sets input-full (bit 1) and clears the command indicator (bit 3) from the next cycle.
- R4: A host read with the data port selected returns the outbound latch in the same cycle and clears output-full (bit 0) from the next cycle.
- R5: A host read with the command port selected returns the status byte in the same cycle and changes no state.
- R6: A controller read strobe (`ctrl_in_rd`) clears input-full from the next cycle. When a host write happens in the same cycle, the write wins: input-full stays 1 and the latch takes the new byte.
- R7: A controller write strobe (`ctrl_out_wr`) loads the outbound latch and sets output-full from the next cycle. When a host data-port read happens in the same cycle, output-full stays 1.
- R8: A controller flag write loads status bits 2, 4 (burst), 5 (SCI event), 6 (SMI event) and 7 from the same bit positions of `ctrl_flag_data`. It leaves bits 0, 1 and 3 unchanged. No host access changes bits 2, 4, 5, 6 or 7.
- R9: The status byte is output-full at bit 0, input-full at bit 1, command indicator at bit 3, and the firmware bits at their R8 positions. The same byte appears on `ctrl_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel_data | input | 1 | 1 selects the data port, 0 the command/status port |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| ctrl_in_rd | input | 1 | Firmware takes the inbound byte |
| ctrl_in_data | output | 8 | Inbound latch contents |
| ctrl_out_wr | input | 1 | Firmware loads the outbound latch |
| ctrl_out_data | input | 8 | Outbound byte from firmware |
| ctrl_flag_wr | input | 1 | Firmware writes its status bits |
| ctrl_flag_data | input | 8 | Firmware status bit values |
| ctrl_status | output | 8 | Status byte as seen by firmware |

## Verification
The hardest cases to reach are the same-cycle collisions. In one, a host write meets the firmware read strobe. In the other, a host data read meets a firmware load. Each collision must keep its buffer-full flag set, even though one of the two sides tries to clear it. Directed steps drive both strobes together in one cycle. The random phase asserts each strobe often and independently, so the collisions also recur with arbitrary latch contents. A bench model tracks every flag, so the check after each cycle also shows that firmware-owned bits survive host traffic.

// File: rtl/mbx_pkg.sv
// Package: status bit positions and firmware-owned mask for the host mailbox.
// Assumes an 8-bit status byte.
package mbx_pkg;
    localparam int unsigned ST_W    = 8;
    localparam int unsigned ST_OBF  = 0;
    localparam int unsigned ST_IBF  = 1;
    localparam int unsigned ST_CMD  = 3;
    // Bits writable only by firmware: 2, 4 (burst), 5 (SCI), 6 (SMI), 7
    localparam logic [ST_W-1:0] FW_MASK = 8'b1111_0100;

    typedef struct packed {
        logic obf;
        logic ibf;
        logic cmd;
    } hw_flags_t;
endpackage

// File: rtl/mbx_inbound.sv
// Inbound path: shared host-to-controller latch, input-full flag and
// command indicator. Assumes single-cycle strobes; a host write in the same
// cycle as a controller read wins.
module mbx_inbound #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_sel_data,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              ctrl_rd,
    output logic [DATA_W-1:0] in_data,
    output logic              ibf,
    output logic              cmd
);
    logic [DATA_W-1:0] latch_q;
    logic              ibf_q;
    logic              cmd_q;

    // Latch the host byte and record which port took it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            cmd_q   <= 1'b0;
        end else if (host_wr) begin
            latch_q <= host_wdata;
            cmd_q   <= ~host_sel_data;
        end
    end

    // Input-full handshake: set by host write, cleared by controller read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ibf_q <= 1'b0;
        else if (host_wr)
            ibf_q <= 1'b1;
        else if (ctrl_rd)
            ibf_q <= 1'b0;
    end

    assign in_data = latch_q;
    assign ibf     = ibf_q;
    assign cmd     = cmd_q;
endmodule

// File: rtl/mbx_outbound.sv
// Outbound path: controller-to-host latch and output-full flag.
// Assumes a controller load in the same cycle as a host data read wins.
module mbx_outbound #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] ctrl_wdata,
    input  logic              host_take,
    output logic [DATA_W-1:0] out_data,
    output logic              obf
);
    logic [DATA_W-1:0] latch_q;
    logic              obf_q;

    // Hold the reply byte loaded by firmware.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= '0;
        else if (ctrl_wr)
            latch_q <= ctrl_wdata;
    end

    // Output-full handshake: set by firmware load, cleared by host read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            obf_q <= 1'b0;
        else if (ctrl_wr)
            obf_q <= 1'b1;
        else if (host_take)
            obf_q <= 1'b0;
    end

    assign out_data = latch_q;
    assign obf      = obf_q;
endmodule

// File: rtl/mbx_fw_flags.sv
// Firmware-owned status bits. Only positions set in MASK get a register;
// the other positions read as zero. Assumes no host path reaches this block.
module mbx_fw_flags #(
    parameter int unsigned     W    = 8,
    parameter logic [W-1:0]    MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] flags
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_reg
            logic bit_q;
            // Load this firmware bit on a flag write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bit_q <= 1'b0;
                else if (wr)
                    bit_q <= wdata[i];
            end
            assign flags[i] = bit_q;
        end else begin : g_zero
            assign flags[i] = 1'b0;
        end
    end
endmodule

// File: rtl/ec_host_mailbox.sv
// Top: host-side mailbox between an OS and an embedded controller.
// Composes the status byte and the host read path. Host reads are
// combinational; side effects take place on the clock edge of the strobe.
module ec_host_mailbox
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel_data,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              ctrl_in_rd,
    output logic [DATA_W-1:0] ctrl_in_data,
    input  logic              ctrl_out_wr,
    input  logic [DATA_W-1:0] ctrl_out_data,
    input  logic              ctrl_flag_wr,
    input  logic [ST_W-1:0]   ctrl_flag_data,
    output logic [ST_W-1:0]   ctrl_status
);
    hw_flags_t         hw;
    logic [DATA_W-1:0] out_latch;
    logic [ST_W-1:0]   fw_bits;
    logic [ST_W-1:0]   status;
    logic              host_take;

    assign host_take = host_rd & host_sel_data;

    mbx_inbound #(.DATA_W(DATA_W)) u_in (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_wr       (host_wr),
        .host_sel_data (host_sel_data),
        .host_wdata    (host_wdata),
        .ctrl_rd       (ctrl_in_rd),
        .in_data       (ctrl_in_data),
        .ibf           (hw.ibf),
        .cmd           (hw.cmd)
    );

    mbx_outbound #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_out_wr),
        .ctrl_wdata (ctrl_out_data),
        .host_take  (host_take),
        .out_data   (out_latch),
        .obf        (hw.obf)
    );

    mbx_fw_flags #(.W(ST_W), .MASK(FW_MASK)) u_fw (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ctrl_flag_wr),
        .wdata (ctrl_flag_data),
        .flags (fw_bits)
    );

    // Merge hardware handshake bits into the firmware-owned byte.
    always_comb begin
        status         = fw_bits;
        status[ST_OBF] = hw.obf;
        status[ST_IBF] = hw.ibf;
        status[ST_CMD] = hw.cmd;
    end

    // Host read mux: data port returns the reply, command port the status.
    always_comb begin
        if (host_sel_data)
            host_rdata = out_latch;
        else
            host_rdata = status;
    end

    assign ctrl_status = status;
endmodule

// File: rtl/mbx_checker.sv
// Checker for ec_host_mailbox: port-level handshake properties.
module mbx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       host_sel_data,
    input logic       host_rd,
    input logic       host_wr,
    input logic [7:0] host_wdata,
    input logic [7:0] host_rdata,
    input logic       ctrl_in_rd,
    input logic [7:0] ctrl_in_data,
    input logic       ctrl_out_wr,
    input logic       ctrl_flag_wr,
    input logic [7:0] ctrl_status
);
    // R2
    cmd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && !host_sel_data |=> ctrl_status[1] && ctrl_status[3]
                                      && ctrl_in_data == $past(host_wdata));
    // R3
    data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_sel_data |=> ctrl_status[1] && !ctrl_status[3]
                                     && ctrl_in_data == $past(host_wdata));
    // R4
    obf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && host_sel_data && !ctrl_out_wr |=> !ctrl_status[0]);
    // R5
    status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && !host_sel_data && !host_wr && !ctrl_in_rd && !ctrl_out_wr
        && !ctrl_flag_wr |=> $stable(ctrl_status));
    // R6
    ibf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_in_rd && !host_wr |=> !ctrl_status[1]);
    // R7
    obf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_out_wr |=> ctrl_status[0]);
    // R8
    fw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_flag_wr |=> $stable(ctrl_status[7:4]) && $stable(ctrl_status[2]));
endmodule

bind ec_host_mailbox mbx_checker u_mbx_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_sel_data (host_sel_data),
    .host_rd       (host_rd),
    .host_wr       (host_wr),
    .host_wdata    (host_wdata),
    .host_rdata    (host_rdata),
    .ctrl_in_rd    (ctrl_in_rd),
    .ctrl_in_data  (ctrl_in_data),
    .ctrl_out_wr   (ctrl_out_wr),
    .ctrl_flag_wr  (ctrl_flag_wr),
    .ctrl_status   (ctrl_status)
);

// File: tb/tb_ec_host_mailbox.sv
module tb_ec_host_mailbox;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] FWM = 8'b1111_0100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sel_data = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
    logic [7:0] host_wdata = '0, host_rdata;
    logic       ctrl_in_rd = 1'b0, ctrl_out_wr = 1'b0, ctrl_flag_wr = 1'b0;
    logic [7:0] ctrl_in_data, ctrl_out_data = '0, ctrl_flag_data = '0, ctrl_status;

    int checks = 0;
    int fails  = 0;

    // Reference model state
    logic [7:0] m_in = '0, m_out = '0, m_fw = '0;
    logic       m_ibf = 0, m_obf = 0, m_cmd = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ec_host_mailbox dut (
        .clk(clk), .rst_n(rst_n),
        .host_sel_data(host_sel_data), .host_rd(host_rd), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ctrl_in_rd(ctrl_in_rd), .ctrl_in_data(ctrl_in_data),
        .ctrl_out_wr(ctrl_out_wr), .ctrl_out_data(ctrl_out_data),
        .ctrl_flag_wr(ctrl_flag_wr), .ctrl_flag_data(ctrl_flag_data),
        .ctrl_status(ctrl_status)
    );

    function automatic logic [7:0] exp_status();
        logic [7:0] s;
        s = m_fw & FWM;
        s[0] = m_obf;
        s[1] = m_ibf;
        s[3] = m_cmd;
        return s;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // One bus cycle; called at a negedge, returns at the next negedge.
    task automatic step(input logic sel, input logic rd, input logic wr,
                        input logic [7:0] wd, input logic crd, input logic cwr,
                        input logic [7:0] cd, input logic fwr, input logic [7:0] fd);
        host_sel_data = sel; host_rd = rd; host_wr = wr; host_wdata = wd;
        ctrl_in_rd = crd; ctrl_out_wr = cwr; ctrl_out_data = cd;
        ctrl_flag_wr = fwr; ctrl_flag_data = fd;
        #1;
        if (rd && sel)  check("R4 data read value", host_rdata, m_out);
        if (rd && !sel) check("R5 status read value", host_rdata, exp_status());
        @(posedge clk);
        if (fwr) m_fw = fd & FWM;
        if (cwr) begin m_out = cd; m_obf = 1; end
        else if (rd && sel) m_obf = 0;
        if (wr) begin m_in = wd; m_ibf = 1; m_cmd = !sel; end
        else if (crd) m_ibf = 0;
        @(negedge clk);
        host_rd = 0; host_wr = 0; ctrl_in_rd = 0; ctrl_out_wr = 0; ctrl_flag_wr = 0;
        check("R9 status byte", ctrl_status, exp_status());
        check("R9 inbound latch", ctrl_in_data, m_in);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 status after reset", ctrl_status, 8'h00);
        check("R1 inbound after reset", ctrl_in_data, 8'h00);
        host_sel_data = 1; #1;
        check("R1 outbound after reset", host_rdata, 8'h00);
        @(negedge clk);

        // R2 command write
        step(0, 0, 1, 8'hA5, 0, 0, 0, 0, 0);
        check("R2 ibf+cmd", ctrl_status & 8'h0A, 8'h0A);
        // R3 data write clears cmd
        step(1, 0, 1, 8'h3C, 0, 0, 0, 0, 0);
        check("R3 cmd cleared", {7'b0, ctrl_status[3]}, 8'h00);
        check("R3 latch", ctrl_in_data, 8'h3C);
        // R6 collision: host write and controller read together
        step(0, 0, 1, 8'h77, 1, 0, 0, 0, 0);
        check("R6 ibf held on collision", {7'b0, ctrl_status[1]}, 8'h01);
        step(0, 0, 0, 0, 1, 0, 0, 0, 0);
        check("R6 ibf cleared", {7'b0, ctrl_status[1]}, 8'h00);
        // R7 load reply, then collision with host data read
        step(0, 0, 0, 0, 0, 1, 8'h5A, 0, 0);
        check("R7 obf set", {7'b0, ctrl_status[0]}, 8'h01);
        step(1, 1, 0, 0, 0, 1, 8'hC3, 0, 0);
        check("R7 obf held on collision", {7'b0, ctrl_status[0]}, 8'h01);
        // R4 host read clears obf
        step(1, 1, 0, 0, 0, 0, 0, 0, 0);
        check("R4 obf cleared", {7'b0, ctrl_status[0]}, 8'h00);
        // R8 flag write masked to firmware bits
        step(0, 0, 0, 0, 0, 0, 0, 1, 8'hFF);
        check("R8 fw bits only", ctrl_status & 8'h0B, exp_status() & 8'h0B);
        check("R8 fw bits set", ctrl_status & FWM, FWM);
        // R5 status read with no side effect; host writes leave fw bits
        step(0, 1, 0, 0, 0, 0, 0, 0, 0);
        step(1, 1, 1, 8'h00, 0, 0, 0, 0, 0);
        check("R8 host leaves fw bits", ctrl_status & FWM, FWM);

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0], r[1], r[2], 8'($urandom), r[3], r[4] & r[5],
                 8'($urandom), r[6] & r[7] & r[8], 8'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule